// File: doc/BRIEF.md
# External Bus Cycle Controller

This block converts read and write requests from an on-chip master into cycles on an external bus. The low address lines are multiplexed with the data lines. Each cycle starts with a one-clock address latch pulse, during which the low address is placed on the shared lines. A strobe phase follows, in which the read strobe or one or both byte write strobes are low. A ready input can stretch the strobe phase. The cycle closes with a one-clock end phase that acknowledges the request. Four active-low chip selects are decoded from the upper address byte using static base/mask pairs.

The external data path runs either 16 or 8 bits wide. A pin selects 8-bit operation for every area. Alternatively, chip-select areas 1 to 3 can each be marked as 8-bit on their own. On an 8-bit path, a full-word request becomes two byte cycles, and the read bytes are merged into one word.

A separate request/acknowledge pair lets another master take the bus. The block grants the bus only between cycles. While the bus is granted, every bus output is released through two output-enable signals. After the bus is returned, there is one idle clock before the next access starts. Requests that fall below the external area boundary are not handled here.

Top module: `ext_bus_ctrl`

## Requirements
- R1: `ale_o` is high for exactly one clock, and the clock that follows is always the first strobe clock. While `ale_o` is high, `ad_oe_o` is high and {`a_hi_o`,`ad_o`} carries the cycle address. A 16-bit cycle presents the request address with bit 0 cleared.
- R2: `rd_no` is low only in the strobe phase of a read. `wrl_no` and `wrh_no` are low only in the strobe phase of a write, and never in the same clock as `rd_no`. On a 16-bit path, `be_i[0]` selects `wrl_no` (low lane, bits 7:0) and `be_i[1]` selects `wrh_no` (high lane, bits 15:8).
- R3: The strobe phase lasts one clock plus one clock for every clock edge at which `rdy_i` is sampled low. During that time the strobes do not change. A single byte cycle therefore spans ADDR, STROBE (1+W clocks) and END, and its acknowledge appears 3+W clocks after the request is accepted.
- R4: `ack_o` is a one-clock pulse, given only in the END clock of the last byte cycle of a request. `rdata_o` is valid with it, and any byte lane not enabled by `be_i` reads as zero.
- R5: A bus request (`hold_ni` low) is granted only between cycles. A request already in progress, including both halves of a split request, completes and is acknowledged before `hlda_no` falls.
- R6: While the bus is granted, `hlda_no`, `ctl_oe_o` and `ad_oe_o` are all low. No ALE pulse or acknowledge is produced for external requests, which wait.
- R7: When `hold_ni` returns high, `hlda_no` and `ctl_oe_o` rise in the same clock, with `ale_o` low. A waiting access raises `ale_o` in the clock after that.
- R8: Area n matches when ((`addr_i[23:16]` ^ base_n) & mask_n) == 0, with base_n and mask_n in bits [8n+7:8n] of `cs_base_i` and `cs_mask_i`. When several areas match, the lowest-numbered one wins. `cs_no[n]` is low from the ALE clock through the END clock. When no area matches, every chip select stays high.
- R9: On an 8-bit path, a request with `be_i`=2'b11 runs as two byte cycles, each with its own ALE pulse. The even address goes first and the odd address second. Only `wrl_no` strobes. During a write, both lanes of `ad_o` carry the current byte, and the read bytes are merged into `rdata_o` by address.
- R10: With `width8_i` high, every access uses an 8-bit path. With it low, an access uses an 8-bit path only when it falls in area k (k=1..3) and `area8_i[k-1]` is set. Area 0 and unmatched accesses stay 16 bits wide.
- R11: On an 8-bit path, a single-byte request runs one cycle at address bit 0 = `be_i[1]`.
- R12: A request with an address below `INT_TOP` (default 24'h002000) produces no ALE and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables (bit 0 low byte) |
| ack_o | output | 1 | Request done, one clock |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| width8_i | input | 1 | High selects an 8-bit bus for all areas |
| area8_i | input | 3 | Per-area 8-bit select for areas 1..3 |
| cs_base_i | input | 32 | Four area bases, 8 bits each |
| cs_mask_i | input | 32 | Four area compare masks, 8 bits each |
| rdy_i | input | 1 | Low stretches the strobe phase |
| hold_ni | input | 1 | Low requests the bus |
| hlda_no | output | 1 | Low while the bus is granted |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe |
| wrl_no | output | 1 | Low-byte write strobe |
| wrh_no | output | 1 | High-byte write strobe |
| cs_no | output | 4 | Chip selects |
| a_hi_o | output | 8 | Upper address lines |
| ad_o | output | 16 | Multiplexed address/write data out |
| ad_i | input | 16 | Multiplexed read data in |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| ctl_oe_o | output | 1 | Drive enable for strobes, ALE, chip selects, upper address |

## Verification
Some properties hold at every clock edge, and assertions check them on every cycle. ALE is a single clock that always leads into a strobe. Read and write strobes never overlap. Strobes stay frozen while ready is low. The acknowledge is a single pulse. At most one chip select is active. The bus is granted only from a strobe-free clock, and every output enable is released during the grant. Release restores the enables together with the acknowledge line. Other behaviour can only be shown by the bench scenarios: the exact cycle count under waits, the priority among overlapping areas, the byte ordering and address of split cycles, the merged read data, per-area width selection, a grant request arriving in the middle of a split access, and internal addresses being ignored.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ADDR  = 3'd1,
    S_STRB  = 3'd2,
    S_END   = 3'd3,
    S_HOLD  = 3'd4,
    S_RECOV = 3'd5
  } ebc_state_e;
endpackage

// File: rtl/ebc_cs_decode.sv
module ebc_cs_decode #(
  parameter int NCS = 4,
  parameter int TW  = 8,
  localparam int IW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [TW-1:0]     tag_i,
  input  logic [NCS*TW-1:0] base_i,
  input  logic [NCS*TW-1:0] mask_i,
  output logic              hit_o,
  output logic [IW-1:0]     idx_o,
  output logic [NCS-1:0]    sel_o
);
  logic [NCS-1:0] match;

  for (genvar g = 0; g < NCS; g++) begin : g_area
    assign match[g] = ~|((tag_i ^ base_i[g*TW +: TW]) & mask_i[g*TW +: TW]);
  end

  // lowest matching area wins
  always_comb begin
    sel_o = '0;
    idx_o = '0;
    for (int i = NCS-1; i >= 0; i--) begin
      if (match[i]) begin
        sel_o = '0;
        sel_o[i] = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       hold_req_i,
  input  logic       rdy_i,
  input  logic       more_i,
  output ebc_state_e state_o,
  output logic       load_o,
  output logic       advance_o,
  output logic       cap_o
);
  ebc_state_e state_q, state_d;
  logic       between;

  assign between   = (state_q == S_IDLE) || (state_q == S_RECOV);
  assign load_o    = between && !hold_req_i && go_i;
  assign advance_o = (state_q == S_END) && more_i;
  assign cap_o     = (state_q == S_STRB) && rdy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_RECOV: begin
        if (hold_req_i)  state_d = S_HOLD;
        else if (go_i)   state_d = S_ADDR;
        else             state_d = S_IDLE;
      end
      S_ADDR:  state_d = S_STRB;
      S_STRB:  if (rdy_i) state_d = S_END;
      S_END:   state_d = more_i ? S_ADDR : S_IDLE;
      S_HOLD:  if (!hold_req_i) state_d = S_RECOV;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: grant entered only from a cycle boundary
  a_r5_hold_from_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && $past(state_q) != S_HOLD) |->
      ($past(state_q) == S_IDLE || $past(state_q) == S_RECOV));

  // R7: release always passes through one recovery clock
  a_r7_recover_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == S_HOLD && state_q != S_HOLD) |-> state_q == S_RECOV);
endmodule

// File: rtl/ebc_lane.sv
module ebc_lane #(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int NCS = 4,
  localparam int BW = DW / 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           advance_i,
  input  logic           cap_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [1:0]     be_i,
  input  logic           eff8_i,
  input  logic [NCS-1:0] cs_i,
  input  logic [DW-1:0]  ad_i,
  output logic [AW-1:0]  bus_addr_o,
  output logic [DW-1:0]  dout_o,
  output logic           rd_en_o,
  output logic           wrl_en_o,
  output logic           wrh_en_o,
  output logic           we_o,
  output logic           more_o,
  output logic [NCS-1:0] cs_o,
  output logic [DW-1:0]  rdata_o
);
  logic [AW-1:1]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [1:0]     be_q;
  logic           we_q, eff8_q, phase_q;
  logic [NCS-1:0] cs_q;
  logic           split, byte_sel;
  logic [BW-1:0]  bdat;

  assign split    = eff8_q && (&be_q);
  assign byte_sel = split ? phase_q : be_q[1];
  assign bdat     = byte_sel ? wdata_q[DW-1:BW] : wdata_q[BW-1:0];

  assign bus_addr_o = {addr_q, eff8_q ? byte_sel : 1'b0};
  assign dout_o     = eff8_q ? {bdat, bdat} : wdata_q;
  assign rd_en_o    = !we_q;
  assign wrl_en_o   = we_q && (eff8_q || be_q[0]);
  assign wrh_en_o   = we_q && !eff8_q && be_q[1];
  assign we_o       = we_q;
  assign more_o     = split && !phase_q;
  assign cs_o       = cs_q;
  assign rdata_o    = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      eff8_q  <= 1'b0;
      cs_q    <= '0;
      phase_q <= 1'b0;
      rdata_q <= '0;
    end else if (load_i) begin
      addr_q  <= addr_i[AW-1:1];
      wdata_q <= wdata_i;
      be_q    <= be_i;
      we_q    <= we_i;
      eff8_q  <= eff8_i;
      cs_q    <= cs_i;
      phase_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (advance_i) phase_q <= 1'b1;
      if (cap_i && !we_q) begin
        if (!eff8_q)       rdata_q <= ad_i & {{BW{be_q[1]}}, {BW{be_q[0]}}};
        else if (byte_sel) rdata_q[DW-1:BW] <= ad_i[BW-1:0];
        else               rdata_q[BW-1:0]  <= ad_i[BW-1:0];
      end
    end
  end

  // R9: second byte only after first, only for a split request
  a_r9_split_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |-> (split && !phase_q));

  // R9: high write strobe never enabled on an 8-bit path
  a_r9_no_high_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff8_q |-> !wrh_en_o);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int          AW      = 24,
  parameter int          DW      = 16,
  parameter int          NCS     = 4,
  parameter logic [23:0] INT_TOP = 24'h002000,
  localparam int TW = AW - DW,
  localparam int IW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [1:0]        be_i,
  output logic              ack_o,
  output logic [DW-1:0]     rdata_o,
  input  logic              width8_i,
  input  logic [NCS-2:0]    area8_i,
  input  logic [NCS*TW-1:0] cs_base_i,
  input  logic [NCS*TW-1:0] cs_mask_i,
  input  logic              rdy_i,
  input  logic              hold_ni,
  output logic              hlda_no,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wrl_no,
  output logic              wrh_no,
  output logic [NCS-1:0]    cs_no,
  output logic [TW-1:0]     a_hi_o,
  output logic [DW-1:0]     ad_o,
  input  logic [DW-1:0]     ad_i,
  output logic              ad_oe_o,
  output logic              ctl_oe_o
);
  ebc_state_e     state;
  logic           is_ext, go, load, advance, cap, more;
  logic           hit, eff8;
  logic [IW-1:0]  idx;
  logic [NCS-1:0] sel, cs_lat, narrow_v;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  dout;
  logic           rd_en, wrl_en, wrh_en, we_lat;
  logic           in_cyc, strb;

  assign is_ext   = addr_i >= AW'(INT_TOP);
  assign go       = req_i && is_ext;
  assign narrow_v = {area8_i, 1'b0};
  assign eff8     = width8_i || (hit && narrow_v[idx]);

  ebc_cs_decode #(.NCS(NCS), .TW(TW)) u_dec (
    .tag_i  (addr_i[AW-1:DW]),
    .base_i (cs_base_i),
    .mask_i (cs_mask_i),
    .hit_o  (hit),
    .idx_o  (idx),
    .sel_o  (sel)
  );

  ebc_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .hold_req_i (!hold_ni),
    .rdy_i      (rdy_i),
    .more_i     (more),
    .state_o    (state),
    .load_o     (load),
    .advance_o  (advance),
    .cap_o      (cap)
  );

  ebc_lane #(.AW(AW), .DW(DW), .NCS(NCS)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .advance_i  (advance),
    .cap_i      (cap),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .eff8_i     (eff8),
    .cs_i       (sel),
    .ad_i       (ad_i),
    .bus_addr_o (bus_addr),
    .dout_o     (dout),
    .rd_en_o    (rd_en),
    .wrl_en_o   (wrl_en),
    .wrh_en_o   (wrh_en),
    .we_o       (we_lat),
    .more_o     (more),
    .cs_o       (cs_lat),
    .rdata_o    (rdata_o)
  );

  assign strb   = (state == S_STRB);
  assign in_cyc = (state == S_ADDR) || strb || (state == S_END);

  assign ale_o    = (state == S_ADDR);
  assign rd_no    = !(strb && rd_en);
  assign wrl_no   = !(strb && wrl_en);
  assign wrh_no   = !(strb && wrh_en);
  assign cs_no    = in_cyc ? ~cs_lat : '1;
  assign a_hi_o   = bus_addr[AW-1:DW];
  assign ad_o     = ale_o ? bus_addr[DW-1:0] : dout;
  assign ad_oe_o  = ale_o || (we_lat && (strb || state == S_END));
  assign ctl_oe_o = (state != S_HOLD);
  assign hlda_no  = (state != S_HOLD);
  assign ack_o    = (state == S_END) && !more;

  // R1: one-clock ALE leading straight into a strobe, address driven
  a_r1_ale_then_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && (!rd_no || !wrl_no || !wrh_no)));
  a_r1_addr_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o);

  // R2: read and write strobes never together
  a_r2_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && (!wrl_no || !wrh_no)));

  // R3: strobes frozen while ready low
  a_r3_wait_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no || !wrl_no || !wrh_no) && !rdy_i) |=>
      ($stable({rd_no, wrl_no, wrh_no}) && !ale_o));

  // R4: ack is a single pulse
  a_r4_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R5: grant taken only from a strobe-free, ack-free clock
  a_r5_grant_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_no) |-> $past(rd_no && wrl_no && wrh_no && !ale_o && !ack_o));

  // R6: everything released while granted
  a_r6_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hlda_no |-> (!ctl_oe_o && !ad_oe_o && !ack_o && !ale_o));

  // R7: enables return with hlda, no ALE in that clock
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_no) |-> (ctl_oe_o && !ale_o));

  // R8: at most one chip select
  a_r8_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  // R12: internal request alone never starts a cycle
  a_r12_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE && req_i && !is_ext) |=> !ale_o);
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  be_i = 2'b11;
  logic        ack_o;
  logic [15:0] rdata_o;
  logic        width8_i = 1'b0;
  logic [2:0]  area8_i = 3'b010;
  logic [31:0] cs_base_i = {8'h00, 8'h30, 8'h20, 8'h10};
  logic [31:0] cs_mask_i = {8'h80, 8'hFF, 8'hFF, 8'hF0};
  logic        rdy_i = 1'b1, hold_ni = 1'b1;
  logic        hlda_no, ale_o, rd_no, wrl_no, wrh_no, ad_oe_o, ctl_oe_o;
  logic [3:0]  cs_no;
  logic [7:0]  a_hi_o;
  logic [15:0] ad_o, ad_i;
  logic [23:0] lat = '0;

  int tests = 0, fails = 0, ticks = 0;

  always #2 clk_i = ~clk_i;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .be_i, .ack_o, .rdata_o,
    .width8_i, .area8_i, .cs_base_i, .cs_mask_i, .rdy_i, .hold_ni, .hlda_no,
    .ale_o, .rd_no, .wrl_no, .wrh_no, .cs_no, .a_hi_o, .ad_o, .ad_i, .ad_oe_o,
    .ctl_oe_o
  );

  function automatic logic [7:0] bytef(input logic [23:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  // external latch and memory model
  always @(negedge clk_i) if (ale_o) lat <= {a_hi_o, ad_o};
  assign ad_i = {bytef({lat[23:1], 1'b1}), bytef(lat)};

  always @(posedge clk_i) begin
    ticks <= ticks + 1;
    if (ticks > 20000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog expired act=%0d exp=<20000", ticks);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic        w8;
    logic [3:0]  waits;
    logic [3:0]  cs;
    logic [1:0]  ales;
    logic [23:0] lat;
    logic        rd, wl, wh;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 24'h100010, 16'h0000, 2'b11, 1'b0, 4'd0, 4'b1110, 2'd1, 24'h100010, 1'b1, 1'b0, 1'b0, 16'h2D2C},
    '{1'b1, 24'h120020, 16'hBEEF, 2'b11, 1'b0, 4'd2, 4'b1110, 2'd1, 24'h120020, 1'b0, 1'b1, 1'b1, 16'hBEEF},
    '{1'b1, 24'h200041, 16'h1234, 2'b10, 1'b0, 4'd0, 4'b1101, 2'd1, 24'h200040, 1'b0, 1'b0, 1'b1, 16'h1234},
    '{1'b1, 24'h300100, 16'hA55A, 2'b11, 1'b0, 4'd1, 4'b1011, 2'd2, 24'h300100, 1'b0, 1'b1, 1'b0, 16'h5A5A},
    '{1'b0, 24'h300102, 16'h0000, 2'b11, 1'b0, 4'd1, 4'b1011, 2'd2, 24'h300102, 1'b1, 1'b0, 1'b0, 16'h3F3E},
    '{1'b0, 24'h450006, 16'h0000, 2'b10, 1'b1, 4'd0, 4'b0111, 2'd1, 24'h450007, 1'b1, 1'b0, 1'b0, 16'h3B00},
    '{1'b1, 24'h800008, 16'hC3D4, 2'b11, 1'b1, 4'd0, 4'b1111, 2'd2, 24'h800008, 1'b0, 1'b1, 1'b0, 16'hD4D4},
    '{1'b0, 24'h200004, 16'h0000, 2'b01, 1'b0, 4'd3, 4'b1101, 2'd1, 24'h200004, 1'b1, 1'b0, 1'b0, 16'h0038}
  };

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    int cyc = 0, ales = 0, scnt = 0;
    bit rd_s = 0, wl_s = 0, wh_s = 0, got = 0, dgot = 0;
    logic [3:0]  cs_s = 4'hF;
    logic [23:0] lat_s = '0;
    logic [15:0] dout_s = '0, rd_v = '0;
    bit strobe;
    we_i = v.we; addr_i = v.addr; wdata_i = v.wdata; be_i = v.be; width8_i = v.w8;
    req_i = 1'b1;
    while (!got && cyc < 40) begin
      @(negedge clk_i);
      cyc++;
      strobe = !rd_no || !wrl_no || !wrh_no;
      if (ale_o) begin
        ales++;
        scnt = 0;
        if (ales == 1) begin cs_s = cs_no; lat_s = {a_hi_o, ad_o}; end
      end
      if (!rd_no) rd_s = 1;
      if (!wrl_no) wl_s = 1;
      if (!wrh_no) wh_s = 1;
      if (strobe && !dgot) begin dout_s = ad_o; dgot = 1; end
      if (strobe) begin scnt++; rdy_i = (scnt > v.waits); end
      else rdy_i = 1'b1;
      if (ack_o) begin got = 1; rd_v = rdata_o; end
    end
    req_i = 1'b0;
    rdy_i = 1'b1;
    chk(got, "R4 ack seen", 32'(got), 32'd1);
    chk(cyc == int'(v.ales) * (3 + int'(v.waits)), "R3 cycle count", 32'(cyc),
        32'(int'(v.ales) * (3 + int'(v.waits))));
    chk(ales == int'(v.ales), "R9 ale pulses", 32'(ales), 32'(v.ales));
    chk(cs_s == v.cs, "R8 chip select", 32'(cs_s), 32'(v.cs));
    chk(lat_s == v.lat, "R1 R11 latched address", 32'(lat_s), 32'(v.lat));
    chk({rd_s, wl_s, wh_s} == {v.rd, v.wl, v.wh}, "R2 strobes used",
        32'({rd_s, wl_s, wh_s}), 32'({v.rd, v.wl, v.wh}));
    if (v.we) chk(dout_s == v.exp, "R9 R10 write data", 32'(dout_s), 32'(v.exp));
    else      chk(rd_v == v.exp, "R4 R9 read data", 32'(rd_v), 32'(v.exp));
    @(negedge clk_i);
    chk(!ack_o, "R4 ack single pulse", 32'(ack_o), 32'd0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    chk({hlda_no, ale_o, rd_no, wrl_no, wrh_no, ack_o, ctl_oe_o} == 7'b1011101,
        "R6 reset outputs", 32'({hlda_no, ale_o, rd_no, wrl_no, wrh_no, ack_o, ctl_oe_o}), 32'h5D);
    chk(cs_no == 4'hF, "R8 reset chip selects", 32'(cs_no), 32'hF);

    for (int i = 0; i < 8; i++) run_vec(i);

    // R12: internal address ignored
    we_i = 1'b0; addr_i = 24'h000100; be_i = 2'b11; width8_i = 1'b0; req_i = 1'b1;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      if (ale_o || ack_o) n++;
    end
    req_i = 1'b0;
    chk(n == 0, "R12 internal request ignored", 32'(n), 32'd0);

    // R6/R7: grant while idle, request waits, release
    hold_ni = 1'b0;
    @(negedge clk_i);
    chk(!hlda_no && !ctl_oe_o && !ad_oe_o, "R6 bus released",
        32'({hlda_no, ctl_oe_o, ad_oe_o}), 32'd0);
    addr_i = 24'h100010; req_i = 1'b1;
    n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      if (ale_o || ack_o || hlda_no) n++;
    end
    chk(n == 0, "R6 external request stalled", 32'(n), 32'd0);
    hold_ni = 1'b1;
    @(negedge clk_i);
    chk(hlda_no && ctl_oe_o && !ale_o, "R7 release clock",
        32'({hlda_no, ctl_oe_o, ale_o}), 32'b110);
    @(negedge clk_i);
    chk(ale_o, "R7 access one clock later", 32'(ale_o), 32'd1);
    n = 0;
    while (!ack_o && n < 20) begin @(negedge clk_i); n++; end
    req_i = 1'b0;
    chk(rdata_o == 16'h2D2C, "R7 access after hold data", 32'(rdata_o), 32'h2D2C);

    // R5: grant requested mid split access
    @(negedge clk_i);
    addr_i = 24'h300102; we_i = 1'b0; be_i = 2'b11; req_i = 1'b1;
    @(negedge clk_i);
    hold_ni = 1'b0;
    n = 0;
    begin
      int early = 0, ales = 1;
      while (!ack_o && n < 20) begin
        @(negedge clk_i); n++;
        if (!hlda_no) early++;
        if (ale_o) ales++;
      end
      req_i = 1'b0;
      chk(ack_o && early == 0, "R5 cycle completes before grant", 32'(early), 32'd0);
      chk(ales == 2, "R5 both halves before grant", 32'(ales), 32'd2);
    end
    n = 0;
    while (hlda_no && n < 4) begin @(negedge clk_i); n++; end
    chk(!hlda_no, "R5 grant after boundary", 32'(hlda_no), 32'd0);
    hold_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(hlda_no && ctl_oe_o, "R7 enables restored", 32'({hlda_no, ctl_oe_o}), 32'b11);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule